// File: doc/BRIEF.md
# Zero-Address Stack ALU

This block pairs a 4-bit arithmetic/logic unit with an eight-entry expression stack, in the manner of a zero-address processor core. No operation carries an operand address. Every ALU operation takes its inputs from the top of the stack (TOS) and the entry just under it (NOS). A two-operand operation removes both and leaves its result as the new top. A shift or rotate rewrites only the top entry. A carry/borrow flag and a branch flag are kept in a small condition register and updated by every accepted ALU operation.

The stack is loaded with a push request and emptied with a pop request; the popped value leaves on a valid-qualified read port. There is no back-pressure on the read port: the consumer must take `rd_data` in every cycle where `rd_valid` is high. The request inputs are plain strobes that are taken every cycle. When more than one is raised in a cycle, an ALU request wins over a push and a push wins over a pop. The losing requests are dropped, not queued. Overflow and underflow are one-cycle pulses that report a refused request. All outputs are registered, so every effect of a request shows in the cycle after the clock edge that sampled it.

Top module: `stk_alu_unit`

## Requirements
- R1: A push places `push_data` on top of the stack. Up to 8 entries are held. A pop of a non-empty stack removes the top entry and presents it on `rd_data` with `rd_valid` high for exactly one cycle after the sampling edge, in last-in first-out order.
- R2: A push into a stack that already holds 8 entries pulses `overflow` for one cycle and leaves the depth and every stored entry unchanged.
- R3: A pop of an empty stack pulses `underflow`. So does an ALU request that needs more entries than are held (two for opcodes 0–6, one for 7–10). In both cases the stack and both flags stay unchanged.
- R4: Opcode 0 (add) and opcode 1 (add with carry) replace TOS and NOS with (NOS + TOS) mod 16, or (NOS + TOS + carry) mod 16, so the depth drops by one. The carry flag takes the sum's carry out of bit 3.
- R5: Opcode 2 (subtract) and opcode 3 (subtract with borrow) replace TOS and NOS with (NOS − TOS) mod 16, or (NOS − TOS − carry) mod 16. The carry flag is set exactly when a borrow leaves bit 3.
- R6: Opcodes 4, 5 and 6 replace TOS and NOS with NOS AND TOS, NOS OR TOS and NOS XOR TOS respectively, and clear the carry flag.
- R7: After opcodes 0–6 the branch flag is 1 exactly when the 4-bit result is zero.
- R8: Opcode 7 shifts TOS left and opcode 8 shifts TOS right, filling the vacated bit with 0. The carry flag takes the bit shifted out, and the depth is unchanged.
- R9: Opcode 9 rotates TOS left through carry (old carry enters bit 0, old bit 3 goes to carry). Opcode 10 rotates TOS right through carry (old carry enters bit 3, old bit 0 goes to carry).
- R10: After opcodes 7–10 the branch flag equals the new carry flag.
- R11: An ALU request with opcode 11–15 is ignored. It changes neither the stack nor the flags and raises no pulse.
- R12: In one cycle an ALU request takes precedence over a push, and a push over a pop. A lower-ranked request raised alongside a higher one has no effect. At most one of `rd_valid`, `overflow`, `underflow` is high in any cycle.
- R13: After reset the stack is empty, both flags are 0 and `rd_valid`, `overflow`, `underflow` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alu_valid | input | 1 | Request an ALU operation this cycle |
| alu_op | input | 4 | ALU opcode (0–10 defined, 11–15 ignored) |
| push_valid | input | 1 | Request a push of `push_data` |
| push_data | input | 4 | Value to push |
| pop_valid | input | 1 | Request a pop of the top entry |
| rd_valid | output | 1 | `rd_data` holds a popped value this cycle |
| rd_data | output | 4 | Popped value |
| carry | output | 1 | Carry/borrow flag |
| branch | output | 1 | Branch flag |
| overflow | output | 1 | One-cycle pulse: push refused, stack full |
| underflow | output | 1 | One-cycle pulse: pop or operation refused, too few entries |

## Verification
A wrong depth counter shows at the ports only when the stack nears a limit. It appears as an overflow or underflow pulse arriving one request too early or too late, or as a pop that returns a value from the wrong slot. A corrupted stored entry stays hidden until it is popped or consumed by an operation, which may be many cycles later. For that reason every test pattern ends by draining the stack and comparing each value. A wrong flag shows in the cycle after the operation and also shifts the outcome of any later add-with-carry, subtract-with-borrow or rotate. The scoreboard therefore compares both flags after every request, not only after ALU operations.

// File: rtl/stk_pkg.sv
package stk_pkg;

  // Storage command issued by the decoder to the register stack
  typedef enum logic [2:0] {
    MC_NONE  = 3'd0,
    MC_PUSH  = 3'd1,
    MC_POP   = 3'd2,
    MC_REPL1 = 3'd3,  // rewrite top entry in place
    MC_REPL2 = 3'd4   // drop top, rewrite the entry under it
  } mcmd_e;

  localparam logic [3:0] OP_ADD  = 4'd0;
  localparam logic [3:0] OP_ADDC = 4'd1;
  localparam logic [3:0] OP_SUB  = 4'd2;
  localparam logic [3:0] OP_SUBB = 4'd3;
  localparam logic [3:0] OP_AND  = 4'd4;
  localparam logic [3:0] OP_OR   = 4'd5;
  localparam logic [3:0] OP_XOR  = 4'd6;
  localparam logic [3:0] OP_SHL  = 4'd7;
  localparam logic [3:0] OP_SHR  = 4'd8;
  localparam logic [3:0] OP_ROL  = 4'd9;
  localparam logic [3:0] OP_ROR  = 4'd10;

  // Number of stack operands an opcode consumes; 0 marks an unused code
  function automatic logic [1:0] op_arity(input logic [3:0] op);
    if (op <= OP_XOR)      return 2'd2;
    else if (op <= OP_ROR) return 2'd1;
    else                   return 2'd0;
  endfunction

endpackage

// File: rtl/stk_alu.sv
module stk_alu
  import stk_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] nos,
  input  logic [W-1:0] tos,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cout,
  output logic         br
);

  logic [W:0] sum_w;
  logic [W:0] dif_w;
  logic       shift_cls;

  always_comb begin
    sum_w = {1'b0, nos} + {1'b0, tos} + {{W{1'b0}}, (op == OP_ADDC) & cin};
    dif_w = {1'b0, nos} - {1'b0, tos} - {{W{1'b0}}, (op == OP_SUBB) & cin};
  end

  always_comb begin
    res       = '0;
    cout      = 1'b0;
    shift_cls = 1'b0;
    case (op)
      OP_ADD, OP_ADDC: begin
        res  = sum_w[W-1:0];
        cout = sum_w[W];
      end
      OP_SUB, OP_SUBB: begin
        res  = dif_w[W-1:0];
        cout = dif_w[W];          // wrapped into the extra bit on borrow
      end
      OP_AND: res = nos & tos;
      OP_OR:  res = nos | tos;
      OP_XOR: res = nos ^ tos;
      OP_SHL: begin
        res       = {tos[W-2:0], 1'b0};
        cout      = tos[W-1];
        shift_cls = 1'b1;
      end
      OP_SHR: begin
        res       = {1'b0, tos[W-1:1]};
        cout      = tos[0];
        shift_cls = 1'b1;
      end
      OP_ROL: begin
        res       = {tos[W-2:0], cin};
        cout      = tos[W-1];
        shift_cls = 1'b1;
      end
      OP_ROR: begin
        res       = {cin, tos[W-1:1]};
        cout      = tos[0];
        shift_cls = 1'b1;
      end
      default: ;
    endcase
    br = shift_cls ? cout : (res == '0);
  end

endmodule

// File: rtl/stk_dec.sv
module stk_dec
  import stk_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          alu_valid,
  input  logic [3:0]    alu_op,
  input  logic          push_valid,
  input  logic          pop_valid,
  input  logic [CW-1:0] cnt,
  output mcmd_e         mem_cmd,
  output logic          upd_flags,
  output logic          set_ovf,
  output logic          set_unf,
  output logic          set_rd
);

  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [1:0] need;

  assign need = op_arity(alu_op);

  // Fixed precedence: ALU request, then push, then pop
  always_comb begin
    mem_cmd   = MC_NONE;
    upd_flags = 1'b0;
    set_ovf   = 1'b0;
    set_unf   = 1'b0;
    set_rd    = 1'b0;
    if (alu_valid) begin
      if (need == 2'd0) begin
        // unused opcode: no action at all
      end else if (cnt < CW'(need)) begin
        set_unf = 1'b1;
      end else begin
        mem_cmd   = (need == 2'd2) ? MC_REPL2 : MC_REPL1;
        upd_flags = 1'b1;
      end
    end else if (push_valid) begin
      if (cnt == FULL) set_ovf = 1'b1;
      else             mem_cmd = MC_PUSH;
    end else if (pop_valid) begin
      if (cnt == '0) begin
        set_unf = 1'b1;
      end else begin
        mem_cmd = MC_POP;
        set_rd  = 1'b1;
      end
    end
  end

endmodule

// File: rtl/stk_mem.sv
module stk_mem
  import stk_pkg::*;
#(
  parameter int W     = 4,
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  mcmd_e         cmd,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  tos,
  output logic [W-1:0]  nos,
  output logic [CW-1:0] cnt
);

  logic [DEPTH*W-1:0] flat;
  logic [CW-1:0]      cnt_q;

  // One register per slot; slot i is written when it is the target of
  // the current command given the present depth
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    localparam logic [CW-1:0] AT_PUSH = CW'(i);
    localparam logic [CW-1:0] AT_TOP  = CW'(i + 1);
    localparam logic [CW-1:0] AT_NEXT = CW'(i + 2);
    logic [W-1:0] val_q;
    logic         hit;

    always_comb begin
      hit = ((cmd == MC_PUSH)  && (cnt_q == AT_PUSH)) ||
            ((cmd == MC_REPL1) && (cnt_q == AT_TOP))  ||
            ((cmd == MC_REPL2) && (cnt_q == AT_NEXT) && (i + 2 <= DEPTH));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   val_q <= '0;
      else if (hit) val_q <= wdata;
    end

    assign flat[i*W +: W] = val_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      case (cmd)
        MC_PUSH:         cnt_q <= cnt_q + 1'b1;
        MC_POP, MC_REPL2: cnt_q <= cnt_q - 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    tos = '0;
    nos = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (cnt_q == CW'(i + 1)) tos = flat[i*W +: W];
      if (cnt_q == CW'(i + 2)) nos = flat[i*W +: W];
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/stk_alu_unit.sv
module stk_alu_unit
  import stk_pkg::*;
#(
  parameter int W     = 4,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         alu_valid,
  input  logic [3:0]   alu_op,
  input  logic         push_valid,
  input  logic [W-1:0] push_data,
  input  logic         pop_valid,
  output logic         rd_valid,
  output logic [W-1:0] rd_data,
  output logic         carry,
  output logic         branch,
  output logic         overflow,
  output logic         underflow
);

  localparam int CW = $clog2(DEPTH + 1);

  mcmd_e         mem_cmd;
  logic          upd_flags, set_ovf, set_unf, set_rd;
  logic [CW-1:0] stk_cnt;
  logic [W-1:0]  tos, nos, alu_res, wdata;
  logic          alu_cout, alu_br;
  logic          carry_q, branch_q;

  stk_dec #(.DEPTH(DEPTH)) u_dec (
    .alu_valid (alu_valid),
    .alu_op    (alu_op),
    .push_valid(push_valid),
    .pop_valid (pop_valid),
    .cnt       (stk_cnt),
    .mem_cmd   (mem_cmd),
    .upd_flags (upd_flags),
    .set_ovf   (set_ovf),
    .set_unf   (set_unf),
    .set_rd    (set_rd)
  );

  stk_alu #(.W(W)) u_alu (
    .op  (alu_op),
    .nos (nos),
    .tos (tos),
    .cin (carry_q),
    .res (alu_res),
    .cout(alu_cout),
    .br  (alu_br)
  );

  assign wdata = (mem_cmd == MC_PUSH) ? push_data : alu_res;

  stk_mem #(.W(W), .DEPTH(DEPTH)) u_mem (
    .clk  (clk),
    .rst_n(rst_n),
    .cmd  (mem_cmd),
    .wdata(wdata),
    .tos  (tos),
    .nos  (nos),
    .cnt  (stk_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry_q   <= 1'b0;
      branch_q  <= 1'b0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      overflow  <= set_ovf;
      underflow <= set_unf;
      rd_valid  <= set_rd;
      if (set_rd) rd_data <= tos;
      if (upd_flags) begin
        carry_q  <= alu_cout;
        branch_q <= alu_br;
      end
    end
  end

  assign carry  = carry_q;
  assign branch = branch_q;

endmodule

// File: rtl/stk_alu_chk.sv
module stk_alu_chk #(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          alu_valid,
  input logic [3:0]    alu_op,
  input logic          push_valid,
  input logic          pop_valid,
  input logic          rd_valid,
  input logic          carry,
  input logic          branch,
  input logic          overflow,
  input logic          underflow,
  input logic [CW-1:0] stk_cnt
);

  AST_DEPTH_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    stk_cnt <= CW'(DEPTH)); // R1

  AST_POP_GIVES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (!alu_valid && !push_valid && pop_valid && stk_cnt != '0) |=> rd_valid); // R1

  AST_FULL_PUSH_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (!alu_valid && push_valid && stk_cnt == CW'(DEPTH)) |=> overflow); // R2

  AST_OVF_KEEPS_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> $stable(stk_cnt)); // R2

  AST_UNF_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> ($stable(carry) && $stable(branch) && $stable(stk_cnt))); // R3

  AST_BINARY_DROPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_valid && alu_op <= 4'd6 && stk_cnt >= CW'(2))
      |=> (stk_cnt == $past(stk_cnt) - 1'b1)); // R4

  AST_LOGIC_CLEARS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_valid && alu_op >= 4'd4 && alu_op <= 4'd6 && stk_cnt >= CW'(2))
      |=> !carry); // R6

  AST_SHIFT_KEEPS_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_valid && alu_op >= 4'd7 && alu_op <= 4'd10 && stk_cnt != '0)
      |=> $stable(stk_cnt)); // R8

  AST_SHIFT_BRANCH_IS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_valid && alu_op >= 4'd7 && alu_op <= 4'd10 && stk_cnt != '0)
      |=> (branch == carry)); // R10

  AST_BAD_OP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_valid && alu_op > 4'd10)
      |=> (!underflow && !overflow && !rd_valid && $stable(stk_cnt)
           && $stable(carry) && $stable(branch))); // R11

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rd_valid, overflow, underflow}) <= 1); // R12

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (stk_cnt == '0 && !rd_valid && !overflow && !underflow
                && !carry && !branch)); // R13

endmodule

bind stk_alu_unit stk_alu_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .alu_valid (alu_valid),
  .alu_op    (alu_op),
  .push_valid(push_valid),
  .pop_valid (pop_valid),
  .rd_valid  (rd_valid),
  .carry     (carry),
  .branch    (branch),
  .overflow  (overflow),
  .underflow (underflow),
  .stk_cnt   (stk_cnt)
);

// File: tb/sim_stk_alu_unit.sv
`timescale 1ns/1ps
module sim_stk_alu_unit;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       alu_valid = 1'b0;
  logic [3:0] alu_op = '0;
  logic       push_valid = 1'b0;
  logic [3:0] push_data = '0;
  logic       pop_valid = 1'b0;
  logic       rd_valid;
  logic [3:0] rd_data;
  logic       carry, branch, overflow, underflow;

  always #2.5 clk = ~clk;

  stk_alu_unit u0 (
    .clk(clk), .rst_n(rst_n),
    .alu_valid(alu_valid), .alu_op(alu_op),
    .push_valid(push_valid), .push_data(push_data),
    .pop_valid(pop_valid),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .carry(carry), .branch(branch),
    .overflow(overflow), .underflow(underflow)
  );

  typedef struct {
    logic       rv;
    logic [3:0] rd;
    logic       c;
    logic       b;
    logic       ov;
    logic       un;
    string      tag;
  } exp_t;

  exp_t       sb[$];
  logic [3:0] m_stk[$];
  logic       m_c = 1'b0;
  logic       m_b = 1'b0;
  int         total = 0;
  int         bad = 0;
  logic       ended = 1'b0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  function automatic string tag_of(input logic [3:0] op);
    if (op <= 4'd1)       return "R4 add";
    else if (op <= 4'd3)  return "R5 sub";
    else if (op <= 4'd6)  return "R6 R7 logic";
    else if (op <= 4'd8)  return "R8 R10 shift";
    else if (op <= 4'd10) return "R9 R10 rotate";
    else                  return "R11 unused op";
  endfunction

  // Reference model of one ALU request, written from the requirements
  task automatic model_alu(input logic [3:0] op, output logic un);
    int need, s;
    logic [3:0] t, n, r;
    un = 1'b0;
    need = (op <= 4'd6) ? 2 : (op <= 4'd10) ? 1 : 0;
    if (need == 0) return;
    if (m_stk.size() < need) begin un = 1'b1; return; end
    t = m_stk.pop_back();
    n = (need == 2) ? m_stk.pop_back() : 4'd0;
    r = '0;
    case (op)
      4'd0, 4'd1: begin
        s = int'(n) + int'(t) + ((op == 4'd1) ? int'(m_c) : 0);
        r = 4'(s % 16); m_c = (s > 15);
      end
      4'd2, 4'd3: begin
        s = int'(n) - int'(t) - ((op == 4'd3) ? int'(m_c) : 0);
        r = 4'((s + 32) % 16); m_c = (s < 0);
      end
      4'd4: begin r = n & t; m_c = 1'b0; end
      4'd5: begin r = n | t; m_c = 1'b0; end
      4'd6: begin r = n ^ t; m_c = 1'b0; end
      4'd7: begin r = {t[2:0], 1'b0}; m_c = t[3]; end
      4'd8: begin r = {1'b0, t[3:1]}; m_c = t[0]; end
      4'd9: begin r = {t[2:0], m_c}; m_c = t[3]; end
      default: begin r = {m_c, t[3:1]}; m_c = t[0]; end
    endcase
    m_b = (op >= 4'd7) ? m_c : (r == 4'd0);
    m_stk.push_back(r);
  endtask

  // Driver: one request per call; the expected outcome goes to the scoreboard
  task automatic step(input logic av, input logic [3:0] op, input logic pv,
                      input logic [3:0] pd, input logic qv, input string tag);
    exp_t e;
    @(negedge clk);
    alu_valid = av; alu_op = op; push_valid = pv; push_data = pd; pop_valid = qv;
    e.rv = 1'b0; e.rd = '0; e.ov = 1'b0; e.un = 1'b0; e.tag = tag;
    if (av) begin
      model_alu(op, e.un);
    end else if (pv) begin
      if (m_stk.size() == 8) e.ov = 1'b1;
      else m_stk.push_back(pd);
    end else if (qv) begin
      if (m_stk.size() == 0) e.un = 1'b1;
      else begin e.rv = 1'b1; e.rd = m_stk.pop_back(); end
    end
    e.c = m_c; e.b = m_b;
    @(posedge clk); #1;
    sb.push_back(e);
    alu_valid = 1'b0; push_valid = 1'b0; pop_valid = 1'b0;
  endtask

  task automatic push(input logic [3:0] d);
    step(1'b0, 4'd0, 1'b1, d, 1'b0, "R1 push");
  endtask
  task automatic pop(input string tag);
    step(1'b0, 4'd0, 1'b0, 4'd0, 1'b1, tag);
  endtask
  task automatic op(input logic [3:0] code);
    step(1'b1, code, 1'b0, 4'd0, 1'b0, tag_of(code));
  endtask
  task automatic drain(input string tag);
    while (m_stk.size() > 0) pop(tag);
  endtask

  // Monitor: compares registered outputs one cycle after each request
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk(e.tag, "rd_valid", int'(rd_valid), int'(e.rv));
        if (e.rv) chk(e.tag, "rd_data", int'(rd_data), int'(e.rd));
        chk(e.tag, "carry", int'(carry), int'(e.c));
        chk(e.tag, "branch", int'(branch), int'(e.b));
        chk(e.tag, "overflow", int'(overflow), int'(e.ov));
        chk(e.tag, "underflow", int'(underflow), int'(e.un));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] lf;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13: quiet outputs out of reset
    chk("R13 reset", "rd_valid", int'(rd_valid), 0);
    chk("R13 reset", "carry", int'(carry), 0);
    chk("R13 reset", "branch", int'(branch), 0);
    chk("R13 reset", "overflow", int'(overflow), 0);
    chk("R13 reset", "underflow", int'(underflow), 0);
    pop("R3 R13 empty pop");

    // R4 add and add-with-carry, R7 zero result
    push(4'd3); push(4'd5); op(4'd0); pop("R4 R1 sum");
    push(4'd9); push(4'd9); op(4'd0);
    push(4'd1); op(4'd1); pop("R4 addc");
    push(4'hF); push(4'd1); op(4'd0); pop("R7 zero sum");

    // R5 subtract and borrow chain
    push(4'd3); push(4'd5); op(4'd2); pop("R5 borrow");
    push(4'd5); push(4'd3); op(4'd3); pop("R5 subb");
    push(4'd7); push(4'd7); op(4'd2); pop("R5 R7 zero diff");

    // R6 logic
    push(4'hA); push(4'hC); op(4'd4);
    push(4'h3); op(4'd5);
    push(4'hB); op(4'd6); pop("R6 R7 logic chain");
    push(4'h5); push(4'hA); op(4'd4); pop("R6 R7 and zero");

    // R8 R9 R10 shifts and rotates on one entry
    push(4'h9); op(4'd7); op(4'd7); op(4'd8); op(4'd9); op(4'd9);
    op(4'd10); op(4'd10); op(4'd10); pop("R8 R9 rotate result");
    push(4'h1); op(4'd8); op(4'd8); pop("R8 R10 shr to zero");

    // R3 too few operands
    op(4'd0); op(4'd7);
    push(4'd6); op(4'd2); pop("R3 single entry kept");

    // R2 overflow and R1 LIFO order
    for (int i = 0; i < 8; i++) push(4'(i + 2));
    push(4'hE); push(4'hF);
    drain("R1 R2 lifo after overflow");

    // R11 unused opcodes
    push(4'd4); push(4'd8);
    for (int k = 11; k < 16; k++) op(4'(k));
    drain("R11 stack intact");

    // R12 precedence
    push(4'd2); push(4'd3);
    step(1'b1, 4'd0, 1'b1, 4'hD, 1'b1, "R12 alu wins");
    step(1'b0, 4'd0, 1'b1, 4'hC, 1'b1, "R12 push wins");
    step(1'b1, 4'd12, 1'b1, 4'h1, 1'b0, "R11 R12 unused op still blocks push");
    drain("R12 contents");

    // Mixed stream from an LFSR
    lf = 16'hACE1;
    for (int n = 0; n < 600; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      case (lf[2:0])
        3'd0, 3'd1, 3'd2: push(lf[7:4]);
        3'd3: pop("R1 mixed pop");
        default: op(lf[11:8]);
      endcase
    end
    drain("R1 mixed drain");

    while (sb.size() > 0) @(negedge clk);
    @(negedge clk);
    finish_run();
  end

endmodule